// File: doc/BRIEF.md
# Pipelined Constant Divide-by-48 Unit

This unit takes an unsigned 13-bit operand (0 to 8191) and returns the integer floor of that operand divided by 48 as an 8-bit quotient (0 to 170). It is meant to sit in a datapath where a linear position must be turned into a row index. For example, a frame buffer or line memory with 48 entries per row would use it.

The operand first loses its four low bits, which is an exact divide by 16 as far as the floor is concerned. What remains is a 9-bit value. The divide by 3 is done as a multiply by 171, built from three registered shift-and-add levels, and the quotient is then taken as bits 16 down to 9 of the product. That constant makes the floor exact for every 9-bit value. A valid strobe travels with each operand, so a new operand may enter on every clock and its result leaves three cycles later. Between valid results the quotient output keeps its last value.

Top module: `div48_pipe`

## Requirements
- R1: For every operand 0..8191 presented with `in_vld` high, `out_quot` equals floor(operand / 48) when the matching `out_vld` pulse appears.
- R2: `out_vld` is high in a cycle exactly when `in_vld` was high three rising clock edges earlier (latency 3).
- R3: Operands may be presented on consecutive cycles without gaps; each one produces its own correct result, in order.
- R4: Exact multiples of 48 are never under-reported (48 gives 1, 6000 gives 125, 8112 gives 169).
- R5: The largest operands give the largest quotient: 8191 gives 170, and `out_quot` never exceeds 170 while `out_vld` is high.
- R6: Asserting `rst` (asynchronous, active high) forces `out_vld` and `out_quot` to 0 at once, discarding results in flight.
- R7: While `in_vld` is low, `in_val` is ignored: `out_quot` holds the last valid result and `out_vld` stays low.
- R8: Operands one below a multiple of 48 round down (47 gives 0, 8111 gives 168, 8159 gives 169).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| in_vld | input | 1 | Operand valid strobe |
| in_val | input | 13 | Unsigned operand |
| out_vld | output | 1 | Result valid, three cycles after `in_vld` |
| out_quot | output | 8 | floor(operand / 48) |

## Verification
A wrong shift amount or a dropped term in any adder level shows at the port as a quotient that is wrong by a fixed ratio, three cycles after the operand that exposed it. Because every operand is swept, this appears within the first few dozen results. A truncated reciprocal shows up only as a quotient one too low on certain exact multiples. These are the cases that the R4 boundary inputs and the full sweep catch. A valid flag slipped by one stage, or data registers that load while idle, show as an `out_vld` pulse in the wrong cycle or as a held quotient that changes during idle gaps. The cycle-by-cycle comparison reports either on the first cycle it happens.

// File: rtl/div48_pkg.sv
`timescale 1ns/1ps
package div48_pkg;
    localparam int IN_W    = 13;             // operand width
    localparam int PRE_SH  = 4;              // power-of-two part of 48
    localparam int X_W     = IN_W - PRE_SH;  // width after pre-shift
    localparam int RECIP   = 171;            // reciprocal of 3 scaled by 2^POST_SH
    localparam int POST_SH = 9;
    localparam int R_W     = 8;              // bits needed for RECIP
    localparam int MUL_W   = X_W + R_W;      // product width, never overflows
    localparam int Q_W     = 8;              // quotient width
    localparam int DIVISOR = 48;
    localparam int Q_MAX   = ((1 << IN_W) - 1) / DIVISOR;
    localparam int N_STG   = 3;              // registered adder levels

    // level k: acc_next = (acc << sa) + (operand << sb)
    // 5x -> 85x -> 171x
    function automatic int stg_sa(input int k);
        case (k)
            0:       return 0;
            1:       return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int stg_sb(input int k);
        case (k)
            0:       return 2;
            1:       return 4;
            default: return 0;
        endcase
    endfunction

    // operand is the carried pre-shifted input (1) or the running sum (0)
    function automatic bit stg_use_x(input int k);
        return (k == 0) || (k == N_STG - 1);
    endfunction

    typedef struct packed {
        logic             vld;
        logic [MUL_W-1:0] acc;
        logic [X_W-1:0]   x;
    } stg_t;
endpackage

// File: rtl/d48_prescale.sv
`timescale 1ns/1ps
module d48_prescale
    import div48_pkg::*;
#(
    parameter int SH = PRE_SH
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [X_W-1:0]   x_o,
    output logic [MUL_W-1:0] acc_o
);
    always_comb begin
        x_o   = val_i[IN_W-1:SH];
        acc_o = {{(MUL_W-X_W){1'b0}}, val_i[IN_W-1:SH]};
    end
endmodule

// File: rtl/d48_add_stage.sv
`timescale 1ns/1ps
module d48_add_stage
    import div48_pkg::*;
#(
    parameter int SA    = 0,
    parameter int SB    = 2,
    parameter bit USE_X = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [MUL_W-1:0] acc_i,
    input  logic [X_W-1:0]   x_i,
    output logic             vld_o,
    output logic [MUL_W-1:0] acc_o,
    output logic [X_W-1:0]   x_o
);
    stg_t             st_d, st_q;
    logic [MUL_W-1:0] opnd;

    generate
        if (USE_X) begin : g_opx
            assign opnd = {{(MUL_W-X_W){1'b0}}, x_i};
        end else begin : g_opacc
            assign opnd = acc_i;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.acc = (acc_i << SA) + (opnd << SB);
            st_d.x   = x_i;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign acc_o = st_q.acc;
    assign x_o   = st_q.x;

    // R1
    acc_ge_x_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> (st_q.acc >= {{(MUL_W-X_W){1'b0}}, st_q.x}));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(st_q.acc) && $stable(st_q.x));
endmodule

// File: rtl/div48_pipe.sv
`timescale 1ns/1ps
module div48_pipe
    import div48_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [IN_W-1:0] in_val,
    output logic            out_vld,
    output logic [Q_W-1:0]  out_quot
);
    logic             vld_w [0:N_STG];
    logic [MUL_W-1:0] acc_w [0:N_STG];
    logic [X_W-1:0]   x_w   [0:N_STG];

    d48_prescale #(.SH(PRE_SH)) u_pre (
        .val_i (in_val),
        .x_o   (x_w[0]),
        .acc_o (acc_w[0])
    );
    assign vld_w[0] = in_vld;

    generate
        for (genvar k = 0; k < N_STG; k++) begin : g_stg
            d48_add_stage #(
                .SA    (stg_sa(k)),
                .SB    (stg_sb(k)),
                .USE_X (stg_use_x(k))
            ) u_stg (
                .clk   (clk),
                .rst   (rst),
                .vld_i (vld_w[k]),
                .acc_i (acc_w[k]),
                .x_i   (x_w[k]),
                .vld_o (vld_w[k+1]),
                .acc_o (acc_w[k+1]),
                .x_o   (x_w[k+1])
            );
        end
    endgenerate

    assign out_vld  = vld_w[N_STG];
    assign out_quot = acc_w[N_STG][POST_SH +: Q_W];

    // cycles since reset, saturating, for the latency check
    logic [1:0] cyc_d, cyc_q;
    always_comb begin
        cyc_d = cyc_q;
        if (cyc_q != 2'd3) cyc_d = cyc_q + 2'd1;
    end
    always_ff @(posedge clk or posedge rst) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_d;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    // R5
    quot_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_quot <= Q_W'(Q_MAX)));
endmodule

// File: tb/div48_pipe_tb.sv
`timescale 1ns/1ps
module div48_pipe_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [12:0] in_val = '0;
    logic        out_vld;
    logic [7:0]  out_quot;

    int checks = 0;
    int errors = 0;

    // bench model: [0] newest, [2] due at output now
    bit    mv [3];
    int    mq [3];
    string mt [3];
    int    held = 0;

    div48_pipe u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_val   (in_val),
        .out_vld  (out_vld),
        .out_quot (out_quot)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) begin
            mv[i] = 1'b0;
            mq[i] = 0;
            mt[i] = "";
        end
        held = 0;
    endtask

    task automatic cyc(input bit v, input int val, input string tag);
        @(negedge clk);
        chk("R2 out_vld", int'(out_vld), int'(mv[2]));
        if (mv[2]) begin
            held = mq[2];
            chk(mt[2], int'(out_quot), held);
        end else begin
            chk("R7 idle hold", int'(out_quot), held);
        end
        in_vld = v;
        in_val = val[12:0];
        mv[2] = mv[1]; mq[2] = mq[1]; mt[2] = mt[1];
        mv[1] = mv[0]; mq[1] = mq[0]; mt[1] = mt[0];
        mv[0] = v;
        mq[0] = v ? (val / 48) : 0;
        mt[0] = tag;
    endtask

    function automatic string sweep_tag(input int v);
        if (v % 48 == 0)  return "R4 exact multiple";
        if (v % 48 == 47) return "R8 below multiple";
        if (v >= 8112)    return "R5 top range";
        return "R1 R3 sweep";
    endfunction

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R6 reset state
        chk("R6 reset out_vld", int'(out_vld), 0);
        chk("R6 reset out_quot", int'(out_quot), 0);
        @(negedge clk);
        rst = 1'b0;

        // back-to-back sweep of every operand
        for (int v = 0; v < 8192; v++) cyc(1'b1, v, sweep_tag(v));
        // idle with a live-looking operand: must be ignored
        for (int i = 0; i < 5; i++) cyc(1'b0, 48 * (i + 1), "R7 idle");

        // sparse boundary operands with gaps
        begin
            int pts [8] = '{47, 48, 6000, 8111, 8112, 8159, 8191, 0};
            for (int i = 0; i < 8; i++) begin
                cyc(1'b1, pts[i], "R4 R5 R8 boundary");
                cyc(1'b0, 4095, "R7 gap");
                cyc(1'b0, 8191, "R7 gap");
            end
        end
        for (int i = 0; i < 4; i++) cyc(1'b0, 0, "R7 flush");

        // reset with results in flight
        cyc(1'b1, 6000, "R1 pre-reset");
        cyc(1'b1, 8191, "R1 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        #2;
        chk("R6 midrun out_vld", int'(out_vld), 0);
        chk("R6 midrun out_quot", int'(out_quot), 0);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b1, 96, "R1 after reset");
        for (int i = 0; i < 4; i++) cyc(1'b0, 0, "R7 flush");
        chk("R1 final value", int'(out_quot), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule